// File: doc/BRIEF.md
# Clocked Burst Memory Front End

This block is a small synchronous memory with its own burst engine. A single pulse on the address strobe loads a start address. The block then reads four words on its own from an aligned group of four locations. The upper address bits stay fixed, and the two low bits step through the group in one of two orders: XOR-stepped (interleaved) or wrap-around incrementing (linear). A data-valid flag marks every beat that appears on the read data port.

A static configuration input selects how the read data leaves the block. In flow-through mode, the data comes straight from the array's read register, and a burst completes in a 2-1-1-1 pattern counted from the strobe cycle. In pipelined mode, an extra output register is added, which gives a 3-1-1-1 pattern. In that mode the array is already fetching the next location while the current beat is being driven.

Writes are single-cycle and happen only when the block is idle. A hold input freezes the burst on its current beat. A new strobe during a burst abandons the old burst and starts a new one.

Top module: `burst_sram`

## Requirements
- R1: While `rst_n` is low, `rd_valid` is low and no burst is in progress. After release, `rd_valid` stays low until a burst is started.
- R2: When `wr_en` is high, `addr_strobe` is low and no burst is in progress, `wr_data` is stored at `addr` on that rising edge. Later reads of that location return the stored word.
- R3: After one strobe, the block produces four beats without further addresses. Every beat address keeps the start address above bit 1 and differs only in bits [1:0].
- R4: With `order_lin` = 0 sampled at the strobe, beat k (k = 0..3) reads offset `start[1:0] XOR k`.
- R5: With `order_lin` = 1 sampled at the strobe, beat k reads offset `(start[1:0] + k) mod 4`.
- R6: With `pipe_mode` = 0, call the edge that samples the strobe E0. Beat k is on `rd_data` with `rd_valid` high after edge E(k+1). This is a 2-1-1-1 pattern that counts the strobe cycle as the first.
- R7: With `pipe_mode` = 1, beat k appears after edge E(k+2). This is a 3-1-1-1 pattern, one lead-off cycle later than R6.
- R8: `rd_valid` is high for exactly four cycles per uninterrupted burst with no hold. It is low at all other times and is never high for more than four consecutive cycles.
- R9: Each cycle a burst sees `adv_hold` high issues no beat. `rd_valid` drops for that cycle, `rd_data` keeps its last value, and the burst resumes with the next beat in order when `adv_hold` falls.
- R10: A strobe during a burst aborts it, and no further beat of the old burst is issued. The new burst follows R4 to R7 measured from the new strobe.
- R11: A write request that arrives together with a strobe or while a burst is in progress is ignored and leaves the memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all inputs and outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_strobe | input | 1 | Loads `addr` as a burst start address |
| addr | input | AW (6) | Burst start address, or write address |
| order_lin | input | 1 | Burst order, sampled with the strobe: 0 interleaved, 1 linear |
| adv_hold | input | 1 | Holds the burst on its current beat |
| pipe_mode | input | 1 | Output mode: 0 flow-through, 1 pipelined |
| wr_en | input | 1 | Single-cycle write request |
| wr_data | input | DW (16) | Write data |
| rd_data | output | DW (16) | Read beat data |
| rd_valid | output | 1 | Marks a valid read beat |

## Verification
The hardest situations to reach are the ones where a control input changes in the middle of a burst. These are a hold that lands between two beats, a fresh strobe one beat into a running burst, and write requests that overlap the strobe and the burst window. The directed tasks drive these inputs on the falling edge of a chosen beat cycle. They then check the exact cycle in which `rd_valid` drops or the new burst's first beat appears. For the write cases, the bench reads back the targeted locations in the same burst to show that the memory is unchanged. The plain burst tasks sweep all four start offsets in both orders and both output modes.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

    localparam int BEATS = 4;

    typedef logic [1:0] beat_t;

    // Offset of beat k inside the aligned group of four.
    function automatic beat_t burst_offset(input beat_t start, input beat_t k, input logic lin);
        beat_t r;
        if (lin) r = start + k;
        else     r = start ^ k;
        return r;
    endfunction

endpackage

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_sram_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_i,
    input  logic [AW-1:0] addr_i,
    input  logic          lin_i,
    input  logic          hold_i,
    output logic          busy_o,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o
);

    localparam beat_t LAST_BEAT = beat_t'(BEATS - 1);

    typedef struct packed {
        logic          active;
        logic          lin;
        beat_t         beat;
        logic [AW-1:0] base;
    } gen_st_t;

    gen_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (strobe_i) begin
            st_d.active = 1'b1;
            st_d.lin    = lin_i;
            st_d.beat   = '0;
            st_d.base   = addr_i;
        end else if (st_q.active && !hold_i) begin
            st_d.beat = st_q.beat + 2'd1;
            if (st_q.beat == LAST_BEAT) st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o    = st_q.active;
    assign rd_en_o   = st_q.active && !strobe_i && !hold_i;
    assign rd_addr_o = {st_q.base[AW-1:2], burst_offset(st_q.base[1:0], st_q.beat, st_q.lin)};

    // R10: a strobe always restarts at the supplied start location
    assert_strobe_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |=> (busy_o && rd_addr_o == $past(addr_i)));

    // R9: a held beat keeps its address
    assert_hold_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && hold_i && !strobe_i) |=> (busy_o && $stable(rd_addr_o)));

    // R3: the group address never moves inside a burst
    assert_group_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !strobe_i) |=> (!busy_o || rd_addr_o[AW-1:2] == $past(rd_addr_o[AW-1:2])));

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o,
    output logic          rvalid_o
);

    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } rd_st_t;

    logic [DW-1:0] mem [DEPTH];
    rd_st_t rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (we_i) mem[waddr_i] <= wdata_i;
    end

    always_comb begin
        rd_d       = rd_q;
        rd_d.valid = re_i;
        if (re_i) rd_d.data = mem[raddr_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata_o  = rd_q.data;
    assign rvalid_o = rd_q.valid;

    // R11: the write port is never used while a burst reads
    assert_no_write_in_burst_R11: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> !re_i);

    // R3: every issued read yields a beat on the next cycle
    assert_read_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
        re_i |=> rvalid_o);

endmodule

// File: rtl/burst_out_stage.sv
module burst_out_stage #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_i,
    input  logic [DW-1:0] data_i,
    input  logic          valid_i,
    output logic [DW-1:0] data_o,
    output logic          valid_o
);

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        st_d.valid = valid_i;
        st_d.data  = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o  = pipe_i ? st_q.data  : data_i;
    assign valid_o = pipe_i ? st_q.valid : valid_i;

    // R7: in pipelined mode the flag trails the array by one cycle
    assert_pipe_lag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_i && $past(pipe_i)) |-> (valid_o == $past(valid_i)));

endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          addr_strobe,
    input  logic [AW-1:0] addr,
    input  logic          order_lin,
    input  logic          adv_hold,
    input  logic          pipe_mode,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);

    localparam int RUN_W = $clog2(BEATS + 1);

    logic          busy;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic          mem_we;
    logic [DW-1:0] arr_data;
    logic          arr_valid;

    assign mem_we = wr_en && !addr_strobe && !busy;

    burst_addr_gen #(.AW(AW)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_i  (addr_strobe),
        .addr_i    (addr),
        .lin_i     (order_lin),
        .hold_i    (adv_hold),
        .busy_o    (busy),
        .rd_en_o   (rd_en),
        .rd_addr_o (rd_addr)
    );

    burst_sram_array #(.AW(AW), .DW(DW)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (mem_we),
        .waddr_i  (addr),
        .wdata_i  (wr_data),
        .re_i     (rd_en),
        .raddr_i  (rd_addr),
        .rdata_o  (arr_data),
        .rvalid_o (arr_valid)
    );

    burst_out_stage #(.DW(DW)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .pipe_i  (pipe_mode),
        .data_i  (arr_data),
        .valid_i (arr_valid),
        .data_o  (rd_data),
        .valid_o (rd_valid)
    );

    // Checker state: length of the current run of valid beats.
    logic [RUN_W-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (!rd_valid)                    run_d = '0;
        else if (run_q != RUN_W'(BEATS))  run_d = run_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    // R8: never more than four back-to-back valid beats
    assert_four_beats_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (run_q < RUN_W'(BEATS)));

    // R1: no beat without a burst having been started
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && !$past(busy, 2) && !$past(addr_strobe)) |-> !rd_valid);

endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          addr_strobe = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          order_lin = 1'b0;
    logic          adv_hold = 1'b0;
    logic          pipe_mode = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid;

    logic [DW-1:0] mdl [DEPTH];
    int            n_chk = 0;
    int            n_bad = 0;
    bit            done = 0;

    always #2 clk = ~clk;

    burst_sram #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr_strobe(addr_strobe), .addr(addr),
        .order_lin(order_lin), .adv_hold(adv_hold), .pipe_mode(pipe_mode),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] base, input int k, input bit lin);
        logic [1:0] kk = k[1:0];
        logic [1:0] off = lin ? base[1:0] + kk : base[1:0] ^ kk;
        return {base[AW-1:2], off};
    endfunction

    task automatic expect_beat(input logic [AW-1:0] a, input string req);
        chk(rd_valid === 1'b1, req, {31'd0, rd_valid}, 32'd1);
        chk(rd_data === mdl[a], req, {16'd0, rd_data}, {16'd0, mdl[a]});
    endtask

    task automatic expect_idle(input string req);
        chk(rd_valid === 1'b0, req, {31'd0, rd_valid}, 32'd0);
    endtask

    task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        mdl[a] = d;
    endtask

    // R1: reset state
    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        expect_idle("R1 in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        expect_idle("R1 after release");
    endtask

    // R2: fill the array with single-cycle writes
    task automatic test_fill();
        for (int i = 0; i < DEPTH; i++)
            write_word(AW'(i), DW'((i * 16'h0139) ^ 16'hA5C3 ^ (i << 10)));
    endtask

    // R3-R8: one clean burst
    task automatic run_burst(input logic [AW-1:0] base, input bit lin, input bit pipe);
        string rq = pipe ? "R7" : "R6";
        string oq = lin ? "R5" : "R4";
        @(negedge clk);
        pipe_mode = pipe;
        @(negedge clk);
        addr_strobe = 1'b1; addr = base; order_lin = lin;
        @(negedge clk);
        addr_strobe = 1'b0; addr = ~base; order_lin = ~lin;
        expect_idle({rq, " lead-off"});
        if (pipe) begin
            @(negedge clk);
            expect_idle("R7 extra lead-off");
        end
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            expect_beat(beat_addr(base, k, lin), {oq, " ", rq, " R3 beat"});
        end
        @(negedge clk);
        expect_idle("R8 after four beats");
    endtask

    task automatic test_sweep();
        for (int p = 0; p < 2; p++)
            for (int l = 0; l < 2; l++)
                for (int s = 0; s < 4; s++)
                    run_burst(AW'(8 * (s + 2 * l + 1) + s), l[0], p[0]);
    endtask

    // R9: hold inserts gaps and keeps data
    task automatic test_hold(input int cycles);
        logic [AW-1:0] base = 6'h06;
        @(negedge clk);
        pipe_mode = 1'b0;
        @(negedge clk);
        addr_strobe = 1'b1; addr = base; order_lin = 1'b0;
        @(negedge clk);
        addr_strobe = 1'b0;
        @(negedge clk);
        expect_beat(beat_addr(base, 0, 0), "R9 first beat");
        adv_hold = 1'b1;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            expect_idle("R9 held");
            chk(rd_data === mdl[beat_addr(base, 0, 0)], "R9 data kept",
                {16'd0, rd_data}, {16'd0, mdl[beat_addr(base, 0, 0)]});
        end
        adv_hold = 1'b0;
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            expect_beat(beat_addr(base, k, 0), "R9 resumed beat");
        end
        @(negedge clk);
        expect_idle("R9 end");
    endtask

    // R10: restart mid-burst
    task automatic test_abort();
        logic [AW-1:0] b1 = 6'h09;
        logic [AW-1:0] b2 = 6'h2E;
        @(negedge clk);
        pipe_mode = 1'b0;
        @(negedge clk);
        addr_strobe = 1'b1; addr = b1; order_lin = 1'b1;
        @(negedge clk);
        addr_strobe = 1'b0;
        @(negedge clk);
        expect_beat(beat_addr(b1, 0, 1), "R10 old beat");
        addr_strobe = 1'b1; addr = b2; order_lin = 1'b0;
        @(negedge clk);
        addr_strobe = 1'b0;
        expect_idle("R10 strobe gap");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            expect_beat(beat_addr(b2, k, 0), "R10 new beat");
        end
        @(negedge clk);
        expect_idle("R10 end");
    endtask

    // R11: writes with the strobe or during a burst are dropped
    task automatic test_write_block();
        logic [AW-1:0] base = 6'h10;
        @(negedge clk);
        pipe_mode = 1'b0;
        @(negedge clk);
        addr_strobe = 1'b1; addr = base; order_lin = 1'b0;
        wr_en = 1'b1; wr_data = 16'hDEAD;
        @(negedge clk);
        addr_strobe = 1'b0; addr = 6'h12; wr_data = 16'hBEEF;
        @(negedge clk);
        wr_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            if (k > 0) @(negedge clk);
            expect_beat(beat_addr(base, k, 0), "R11 memory unchanged");
        end
        @(negedge clk);
        write_word(6'h12, 16'h5A0F);
        run_burst(6'h13, 1'b1, 1'b1);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_fill();
        run_burst(6'h00, 1'b0, 1'b0);
        test_sweep();
        test_hold(1);
        test_hold(3);
        test_abort();
        test_write_block();
        repeat (3) @(negedge clk);
        expect_idle("R8 final idle");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule